// File: doc/BRIEF.md
# Ternary Search Array with Priority Resolution

This block holds a table of entries in which every entry pairs a data word with a per-bit mask word, so each stored bit is 0, 1 or don't-care. A lookup presents a search key and picks one of several global mask registers. That register can exclude bits from the comparison for this one search. An entry matches when every bit left unmasked by both its own mask and the chosen global mask equals the key. The lowest matching index wins. The block reports that index together with a hit flag, a lookup-complete flag and a flag for more than one match. It also keeps the hit flag and index in one of several result registers.

All operations share one request port. Each request carries a strobe, an operation code, an address space, an address, a global mask select and a data word. The block accepts one request per clock, and lookups may follow each other on every cycle. The result-register select is a separate field that is sampled one cycle after a lookup's strobe. Reads of entries, masks, global masks and result registers return on the same pipeline as lookup results.

Top module: `tcam_search`

## Requirements
- R1: While `rst` is high, every entry data word, entry mask, global mask register and result register is cleared to zero, and all response outputs are low or zero.
- R2: Operation codes on `req_op` are 0 = lookup, 1 = write, 2 = read and 3 = no operation. Address spaces on `req_space` are 0 = entry data, 1 = entry mask, 2 = global mask and 3 = result register. Global masks and result registers are addressed by the low 2 bits of `req_addr`. A read strobed at rising edge N raises `rd_ack` and drives the addressed word on `rd_data` after edge N+1. Otherwise `rd_ack` is low and `rd_data` is zero.
- R3: An entry matches a key when, at every bit position where both the entry mask bit and the selected global mask bit are 0, the key bit equals the entry data bit. A mask bit of 1 in either mask makes that position don't-care.
- R4: Among matching entries, `rsp_index` reports the lowest index.
- R5: `rsp_hit` is 1 for a lookup with at least one matching entry. On a miss it is 0 and `rsp_index` is 0.
- R6: A lookup strobed at rising edge N raises `rsp_done` for exactly the cycle after edge N+1, whether or not it hits. `rsp_done` is never high otherwise.
- R7: `rsp_multi` is 1 for a completed lookup with two or more matching entries, and is 0 otherwise.
- R8: The `req_rsel` value present at edge N+1 selects the result register that stores the outcome of a lookup strobed at edge N. The stored value is hit in bit 6 and the index in bits 5:0. A result-register read strobed at edge N+1 already returns it.
- R9: Lookups are accepted on consecutive cycles, and each one is compared against every write strobed on an earlier cycle.
- R10: A write to the result-register space, or a strobed operation code 3, changes no stored state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_strobe | input | 1 | Request valid |
| req_op | input | 2 | Operation code |
| req_space | input | 2 | Address space for read and write |
| req_addr | input | 6 | Entry, global mask or result register address |
| req_gsel | input | 2 | Global mask register used by a lookup |
| req_rsel | input | 2 | Result register for the lookup strobed one cycle earlier |
| req_data | input | 72 | Search key or write data |
| rsp_done | output | 1 | Lookup completed |
| rsp_hit | output | 1 | Lookup found a match |
| rsp_multi | output | 1 | Two or more entries matched |
| rsp_index | output | 6 | Lowest matching index |
| rd_ack | output | 1 | Read data valid |
| rd_data | output | 72 | Read data |

## Verification
The bound checker checks on every cycle that the response flags stay consistent with one another: a hit only ever comes with a completed lookup, a multi-match only with a hit, and a miss reports index zero. It also checks that each lookup or read yields exactly one completion or acknowledge two edges after its strobe, and that reset silences the outputs. Other behaviours only show up in the bench's scenarios against its own model. These are the ternary comparison itself, the lowest-index choice, the late result-register select, the visibility of a write to the very next lookup, and the ignored writes.

// File: rtl/tcam_pkg.sv
package tcam_pkg;

    // Array geometry
    parameter int unsigned KEY_W    = 72;
    parameter int unsigned DEPTH    = 64;
    parameter int unsigned N_GMASK  = 4;
    parameter int unsigned N_RESULT = 4;

    localparam int unsigned IDX_W  = $clog2(DEPTH);
    localparam int unsigned GSEL_W = $clog2(N_GMASK);
    localparam int unsigned RSEL_W = $clog2(N_RESULT);
    localparam int unsigned RES_W  = IDX_W + 1;

    typedef enum logic [1:0] {
        OP_LOOKUP = 2'd0,
        OP_WRITE  = 2'd1,
        OP_READ   = 2'd2,
        OP_IDLE   = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        SP_DATA   = 2'd0,
        SP_MASK   = 2'd1,
        SP_GMASK  = 2'd2,
        SP_RESULT = 2'd3
    } space_e;

    typedef logic [KEY_W-1:0] word_t;

    typedef struct packed {
        logic             hit;
        logic [IDX_W-1:0] idx;
    } result_t;

    // A bit set in either mask removes that position from comparison
    function automatic logic ternary_hit(word_t key, word_t data, word_t emask, word_t gmask);
        return &((key ~^ data) | emask | gmask);
    endfunction

endpackage

// File: rtl/tcam_store.sv
module tcam_store
    import tcam_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  space_e            wr_space,
    input  logic [IDX_W-1:0]  wr_addr,
    input  word_t             wr_data,
    input  space_e            rd_space,
    input  logic [IDX_W-1:0]  rd_addr,
    output word_t             rd_word,
    input  logic              res_we,
    input  logic [RSEL_W-1:0] res_sel,
    input  result_t           res_val,
    output word_t             ent_data [DEPTH],
    output word_t             ent_mask [DEPTH],
    output word_t             gmask    [N_GMASK]
);

    result_t res_q [N_RESULT];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                ent_data[i] <= '0;
                ent_mask[i] <= '0;
            end
            for (int g = 0; g < N_GMASK; g++) gmask[g] <= '0;
            for (int r = 0; r < N_RESULT; r++) res_q[r] <= '0;
        end else begin
            if (wr_en) begin
                case (wr_space)
                    SP_DATA:  ent_data[wr_addr] <= wr_data;
                    SP_MASK:  ent_mask[wr_addr] <= wr_data;
                    SP_GMASK: gmask[wr_addr[GSEL_W-1:0]] <= wr_data;
                    default:  ;
                endcase
            end
            if (res_we) res_q[res_sel] <= res_val;
        end
    end

    always_comb begin
        rd_word = '0;
        case (rd_space)
            SP_DATA:   rd_word = ent_data[rd_addr];
            SP_MASK:   rd_word = ent_mask[rd_addr];
            SP_GMASK:  rd_word = gmask[rd_addr[GSEL_W-1:0]];
            SP_RESULT: rd_word[RES_W-1:0] = res_q[rd_addr[RSEL_W-1:0]];
            default:   rd_word = '0;
        endcase
    end

endmodule

// File: rtl/tcam_compare.sv
module tcam_compare
    import tcam_pkg::*;
(
    input  word_t             key,
    input  word_t             gmask,
    input  word_t             ent_data [DEPTH],
    input  word_t             ent_mask [DEPTH],
    output logic [DEPTH-1:0]  match_vec
);

    for (genvar e = 0; e < DEPTH; e++) begin : g_entry
        assign match_vec[e] = ternary_hit(key, ent_data[e], ent_mask[e], gmask);
    end

endmodule

// File: rtl/tcam_prio.sv
module tcam_prio
    import tcam_pkg::*;
(
    input  logic [DEPTH-1:0] match_vec,
    output logic             any_hit,
    output logic [IDX_W-1:0] first_idx,
    output logic             several
);

    always_comb begin
        first_idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (match_vec[i]) first_idx = IDX_W'(i);
        end
        any_hit = |match_vec;
        // Clearing the lowest set bit leaves something only if two or more were set
        several = |(match_vec & (match_vec - DEPTH'(1)));
    end

endmodule

// File: rtl/tcam_search.sv
module tcam_search
    import tcam_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_strobe,
    input  logic [1:0]        req_op,
    input  logic [1:0]        req_space,
    input  logic [IDX_W-1:0]  req_addr,
    input  logic [GSEL_W-1:0] req_gsel,
    input  logic [RSEL_W-1:0] req_rsel,
    input  logic [KEY_W-1:0]  req_data,
    output logic              rsp_done,
    output logic              rsp_hit,
    output logic              rsp_multi,
    output logic [IDX_W-1:0]  rsp_index,
    output logic              rd_ack,
    output logic [KEY_W-1:0]  rd_data
);

    op_e    op_in;
    space_e space_in;
    assign op_in    = op_e'(req_op);
    assign space_in = space_e'(req_space);

    // Stage 1: request capture
    logic              s1_lookup;
    logic              s1_read;
    word_t             s1_key;
    logic [GSEL_W-1:0] s1_gsel;
    space_e            s1_space;
    logic [IDX_W-1:0]  s1_addr;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_lookup <= 1'b0;
            s1_read   <= 1'b0;
            s1_key    <= '0;
            s1_gsel   <= '0;
            s1_space  <= SP_DATA;
            s1_addr   <= '0;
        end else begin
            s1_lookup <= req_strobe && (op_in == OP_LOOKUP);
            s1_read   <= req_strobe && (op_in == OP_READ);
            if (req_strobe) begin
                s1_key   <= req_data;
                s1_gsel  <= req_gsel;
                s1_space <= space_in;
                s1_addr  <= req_addr;
            end
        end
    end

    logic    wr_en;
    word_t   rd_word;
    word_t   ent_data [DEPTH];
    word_t   ent_mask [DEPTH];
    word_t   gmask    [N_GMASK];
    result_t res_val;

    assign wr_en = req_strobe && (op_in == OP_WRITE) && (space_in != SP_RESULT);

    logic [DEPTH-1:0] match_vec;
    logic             any_hit;
    logic             several;
    logic [IDX_W-1:0] first_idx;

    assign res_val.hit = any_hit;
    assign res_val.idx = any_hit ? first_idx : '0;

    tcam_store u_store (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_space (space_in),
        .wr_addr  (req_addr),
        .wr_data  (req_data),
        .rd_space (s1_space),
        .rd_addr  (s1_addr),
        .rd_word  (rd_word),
        .res_we   (s1_lookup),
        .res_sel  (req_rsel),
        .res_val  (res_val),
        .ent_data (ent_data),
        .ent_mask (ent_mask),
        .gmask    (gmask)
    );

    tcam_compare u_compare (
        .key       (s1_key),
        .gmask     (gmask[s1_gsel]),
        .ent_data  (ent_data),
        .ent_mask  (ent_mask),
        .match_vec (match_vec)
    );

    tcam_prio u_prio (
        .match_vec (match_vec),
        .any_hit   (any_hit),
        .first_idx (first_idx),
        .several   (several)
    );

    // Stage 2: registered responses
    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_done  <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_multi <= 1'b0;
            rsp_index <= '0;
            rd_ack    <= 1'b0;
            rd_data   <= '0;
        end else begin
            rsp_done  <= s1_lookup;
            rsp_hit   <= s1_lookup && any_hit;
            rsp_multi <= s1_lookup && several;
            rsp_index <= s1_lookup ? res_val.idx : '0;
            rd_ack    <= s1_read;
            rd_data   <= s1_read ? rd_word : '0;
        end
    end

endmodule

// File: rtl/tcam_search_chk.sv
module tcam_search_chk
    import tcam_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             req_strobe,
    input logic [1:0]       req_op,
    input logic             rsp_done,
    input logic             rsp_hit,
    input logic             rsp_multi,
    input logic [IDX_W-1:0] rsp_index,
    input logic             rd_ack
);

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (!rsp_done && !rsp_hit && !rsp_multi && !rd_ack));

    // R6
    done_follows_lookup_chk: assert property (@(posedge clk) disable iff (rst)
        (req_strobe && req_op == 2'd0) |=> ##1 rsp_done);

    // R6
    done_needs_lookup_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_done |-> $past(req_strobe && req_op == 2'd0, 2));

    // R2
    ack_follows_read_chk: assert property (@(posedge clk) disable iff (rst)
        (req_strobe && req_op == 2'd2) |=> ##1 rd_ack);

    // R2
    ack_needs_read_chk: assert property (@(posedge clk) disable iff (rst)
        rd_ack |-> $past(req_strobe && req_op == 2'd2, 2));

    // R5
    hit_needs_done_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_hit |-> rsp_done);

    // R5
    miss_index_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !rsp_hit |-> (rsp_index == '0));

    // R7
    multi_needs_hit_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_multi |-> rsp_hit);

endmodule

bind tcam_search tcam_search_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_strobe (req_strobe),
    .req_op     (req_op),
    .rsp_done   (rsp_done),
    .rsp_hit    (rsp_hit),
    .rsp_multi  (rsp_multi),
    .rsp_index  (rsp_index),
    .rd_ack     (rd_ack)
);

// File: tb/tcam_search_bench.sv
module tcam_search_bench;
    import tcam_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_strobe = 1'b0;
    logic [1:0]        req_op = 2'd3;
    logic [1:0]        req_space = 2'd0;
    logic [IDX_W-1:0]  req_addr = '0;
    logic [GSEL_W-1:0] req_gsel = '0;
    logic [RSEL_W-1:0] req_rsel = '0;
    logic [KEY_W-1:0]  req_data = '0;
    logic              rsp_done, rsp_hit, rsp_multi, rd_ack;
    logic [IDX_W-1:0]  rsp_index;
    logic [KEY_W-1:0]  rd_data;

    always #2.5ns clk = ~clk;

    tcam_search u_tcam_search (
        .clk(clk), .rst(rst), .req_strobe(req_strobe), .req_op(req_op),
        .req_space(req_space), .req_addr(req_addr), .req_gsel(req_gsel),
        .req_rsel(req_rsel), .req_data(req_data), .rsp_done(rsp_done),
        .rsp_hit(rsp_hit), .rsp_multi(rsp_multi), .rsp_index(rsp_index),
        .rd_ack(rd_ack), .rd_data(rd_data)
    );

    typedef struct {
        logic             done, hit, multi, ack;
        logic [IDX_W-1:0] idx;
        word_t            rdata;
        string            tag;
    } exp_t;

    word_t            m_data [DEPTH];
    word_t            m_mask [DEPTH];
    word_t            m_gm   [N_GMASK];
    logic [RES_W-1:0] m_res  [N_RESULT];
    word_t            base   [4];
    exp_t             ex_a, ex_b;
    logic             pend = 1'b0;
    logic [RES_W-1:0] pend_val = '0;
    int               n_chk = 0, n_fail = 0;
    bit               finished = 0;

    function automatic word_t rword();
        return word_t'({$urandom, $urandom, $urandom});
    endfunction

    function automatic exp_t quiet(string tag);
        exp_t e;
        e.done = 0; e.hit = 0; e.multi = 0; e.ack = 0;
        e.idx = '0; e.rdata = '0; e.tag = tag;
        return e;
    endfunction

    // Independent per-bit model of the ternary search
    function automatic exp_t model_lookup(word_t key, int g, string tag);
        exp_t e = quiet(tag);
        int   cnt = 0;
        e.done = 1;
        for (int i = 0; i < DEPTH; i++) begin
            bit ok = 1;
            for (int b = 0; b < KEY_W; b++)
                if (!m_mask[i][b] && !m_gm[g][b] && key[b] != m_data[i][b]) ok = 0;
            if (ok) begin
                if (cnt == 0) e.idx = IDX_W'(i);
                cnt++;
            end
        end
        e.hit   = (cnt > 0);
        e.multi = (cnt > 1);
        return e;
    endfunction

    task automatic chk(bit ok, string rq, string what, word_t act, word_t expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", rq, what, act, expv);
        end
    endtask

    task automatic check_out(exp_t e);
        chk(rsp_done  === e.done,  "R6", "done",  word_t'(rsp_done),  word_t'(e.done));
        chk(rsp_hit   === e.hit,   "R5", "hit",   word_t'(rsp_hit),   word_t'(e.hit));
        chk(rsp_multi === e.multi, "R7", "multi", word_t'(rsp_multi), word_t'(e.multi));
        chk(rsp_index === e.idx,   e.tag, "index", word_t'(rsp_index), word_t'(e.idx));
        chk(rd_ack    === e.ack,   "R2", "ack",   word_t'(rd_ack),    word_t'(e.ack));
        chk(rd_data   === e.rdata, e.tag, "rdata", rd_data, e.rdata);
    endtask

    // One request per cycle; rsel belongs to the lookup of the previous call
    task automatic step(bit stb, op_e op, space_e sp, int addr, int gsel, int rsel,
                        word_t data, string tag);
        exp_t ne = quiet(tag);
        @(negedge clk);
        check_out(ex_b);
        if (pend) m_res[rsel] = pend_val;
        pend = 0;
        if (stb) begin
            case (op)
                OP_LOOKUP: begin
                    ne = model_lookup(data, gsel, tag);
                    pend = 1;
                    pend_val = {ne.hit, ne.idx};
                end
                OP_WRITE: case (sp)
                    SP_DATA:  m_data[addr] = data;
                    SP_MASK:  m_mask[addr] = data;
                    SP_GMASK: m_gm[addr % N_GMASK] = data;
                    default:  ;
                endcase
                OP_READ: begin
                    ne.ack = 1;
                    case (sp)
                        SP_DATA:  ne.rdata = m_data[addr];
                        SP_MASK:  ne.rdata = m_mask[addr];
                        SP_GMASK: ne.rdata = m_gm[addr % N_GMASK];
                        default:  ne.rdata = word_t'(m_res[addr % N_RESULT]);
                    endcase
                end
                default: ;
            endcase
        end
        ex_b = ex_a;
        ex_a = ne;
        req_strobe = stb;
        req_op     = op;
        req_space  = sp;
        req_addr   = IDX_W'(addr);
        req_gsel   = GSEL_W'(gsel);
        req_rsel   = RSEL_W'(rsel);
        req_data   = data;
    endtask

    initial begin
        word_t a;
        void'($urandom(32'd20240611));
        for (int i = 0; i < DEPTH; i++) begin m_data[i] = '0; m_mask[i] = '0; end
        for (int g = 0; g < N_GMASK; g++) m_gm[g] = '0;
        for (int r = 0; r < N_RESULT; r++) m_res[r] = '0;
        for (int k = 0; k < 4; k++) base[k] = rword();
        ex_a = quiet("R1");
        ex_b = quiet("R1");
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: cleared storage after reset
        step(1, OP_READ, SP_DATA, 0, 0, 0, '0, "R1");
        step(1, OP_READ, SP_MASK, 63, 0, 0, '0, "R1");
        step(1, OP_READ, SP_GMASK, 3, 0, 0, '0, "R1");
        step(1, OP_READ, SP_RESULT, 2, 0, 0, '0, "R1");
        // R4/R7: zero key matches every cleared entry, lowest index wins
        step(1, OP_LOOKUP, SP_DATA, 0, 0, 0, '0, "R4");

        a = 72'h0123456789ABCDEF01;
        step(1, OP_WRITE, SP_DATA, 5, 0, 1, a, "R2");
        // R9: lookup right after the write sees it
        step(1, OP_LOOKUP, SP_DATA, 0, 0, 0, a, "R9");
        // R8: result register 2 receives it, read back at once
        step(1, OP_READ, SP_RESULT, 2, 0, 2, '0, "R8");
        step(1, OP_READ, SP_DATA, 5, 0, 0, '0, "R2");

        // R3: entry mask makes the low byte don't-care
        step(1, OP_WRITE, SP_DATA, 9, 0, 0, a, "R3");
        step(1, OP_WRITE, SP_MASK, 9, 0, 0, 72'hFF, "R3");
        step(1, OP_LOOKUP, SP_DATA, 0, 0, 0, a ^ 72'h5A, "R3");
        step(1, OP_READ, SP_MASK, 9, 0, 1, '0, "R2");

        // R3/R7: global mask excludes the upper bits, both entries hit
        step(1, OP_WRITE, SP_GMASK, 1, 0, 0, 72'hFF_F000_0000_0000_0000, "R3");
        step(1, OP_LOOKUP, SP_DATA, 0, 1, 0, a ^ 72'h3C_1000_0000_0000_0000, "R7");
        step(1, OP_LOOKUP, SP_DATA, 0, 0, 3, a ^ 72'h3C_1000_0000_0000_0000, "R3");
        // R5/R6: miss still completes
        step(1, OP_LOOKUP, SP_DATA, 0, 0, 0, ~a, "R5");
        step(1, OP_READ, SP_RESULT, 0, 0, 0, '0, "R5");
        step(1, OP_READ, SP_RESULT, 3, 0, 0, '0, "R8");

        // R10: result writes and code 3 leave state alone
        step(1, OP_WRITE, SP_RESULT, 2, 0, 0, '1, "R10");
        step(1, OP_IDLE, SP_DATA, 5, 0, 0, '1, "R10");
        step(1, OP_READ, SP_RESULT, 2, 0, 0, '0, "R10");
        step(1, OP_READ, SP_DATA, 5, 0, 0, '0, "R10");

        // Random mix around a few base words
        for (int n = 0; n < 4000; n++) begin
            int    r   = int'($urandom % 100);
            int    ad  = int'($urandom % DEPTH);
            int    gs  = int'($urandom % N_GMASK);
            int    rs  = int'($urandom % N_RESULT);
            word_t key = base[$urandom % 4];
            if ($urandom % 2 == 1) key[$urandom % KEY_W] ^= 1'b1;
            if (r < 55)
                step(1, OP_LOOKUP, SP_DATA, ad, gs, rs, key, "R4");
            else if (r < 65)
                step(1, OP_WRITE, SP_DATA, ad, gs, rs, key, "R2");
            else if (r < 72)
                step(1, OP_WRITE, SP_MASK, ad, gs, rs, rword() & rword() & rword(), "R2");
            else if (r < 74)
                step(1, OP_WRITE, SP_GMASK, ad, gs, rs, rword() & rword() & rword(), "R2");
            else if (r < 92)
                step(1, OP_READ, space_e'($urandom % 4), ad, gs, rs, '0, "R2");
            else if (r < 95)
                step(1, OP_WRITE, SP_RESULT, ad, gs, rs, rword(), "R10");
            else
                step(0, OP_IDLE, SP_DATA, ad, gs, rs, '0, "R6");
        end
        step(0, OP_IDLE, SP_DATA, 0, 0, 0, '0, "R6");
        step(0, OP_IDLE, SP_DATA, 0, 0, 0, '0, "R6");
        step(0, OP_IDLE, SP_DATA, 0, 0, 0, '0, "R6");
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule